// File: doc/BRIEF.md
# USB Host Controller Interrupt Status Unit

This block keeps the interrupt status flags of a USB host controller. Five event sources can each raise one sticky flag: the system bus error logic, the downstream resume detector, the frame timer, the done-list writeback path and the schedule engine. A flag stays at 1 until software clears it by writing a 1 to its bit position. The block combines the flags with a per-flag enable vector and a master enable to form a registered interrupt line.

Two flags have side duties. The done-head flag acts as an interlock: while it is set, the done-list writeback path is not granted a new writeback. The flag is set by the previous writeback, and software must clear it after it has consumed the list head. Every scheduling overrun also advances a small wrapping counter that software can read. The frame-start event also produces a start-of-frame token request. That request rises in the same cycle as the flag, so the two stay aligned.

Top module: `usbh_int_status`

## Requirements
- R1: After reset, all five flags, the enable register, the overrun counter, `irq_o` and `sof_req_o` read 0.
- R2: Writing the status address (0) clears every flag whose data bit is 1. Data bits that are 0, and all data bits above bit 4, leave the flags unchanged.
- R3: If a set event and a software clear hit the same flag in the same cycle, the flag ends up at 1.
- R4: While `sw_resume_i` is high, `resume_det_i` does not set the resume flag (bit 3). When `sw_resume_i` is low, a resume indication sets the flag.
- R5: A `frame_start_i` pulse sets the start-of-frame flag (bit 2). `sof_req_o` is high for exactly the one cycle in which that flag first reads 1.
- R6: `wb_grant_o` is `wb_req_i` gated by the done-head flag (bit 1). While that flag is 1, the grant stays low, and it returns in the cycle after software clears the flag.
- R7: A `wb_done_i` pulse sets the done-head flag (bit 1) in the following cycle.
- R8: A `sched_ovr_i` pulse sets the overrun flag (bit 0) and increments a 2-bit counter. The counter wraps from 3 to 0, reads at address 2 in bits 1:0, and is not changed by writes.
- R9: `irq_o` is registered. It equals the OR over bits 4:0 of (flag AND enable bit), gated by the master enable in bit 5 of the enable register at address 1. It reflects a flag one cycle after that flag first reads 1.
- R10: A status read returns the flags in bits 4:0 and 0 in every bit above. Reads change no state.
- R11: The flag bit positions are: system error at bit 4, resume at bit 3, frame start at bit 2, done-head writeback at bit 1, scheduling overrun at bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sys_err_i | input | 1 | Non-USB system error pulse |
| resume_det_i | input | 1 | Downstream resume signalling seen |
| sw_resume_i | input | 1 | Software is driving resume on the bus |
| frame_start_i | input | 1 | New frame started and frame number stored |
| sched_ovr_i | input | 1 | Schedule overran the frame |
| wb_done_i | input | 1 | Done-list head written to shared memory |
| wb_req_i | input | 1 | Request for a done-list head writeback |
| wb_grant_o | output | 1 | Writeback permitted |
| sof_req_o | output | 1 | Start-of-frame token request |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Register address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational) |
| irq_o | output | 1 | Interrupt request |

## Verification
An event or a register write is captured at the clock edge that samples it. The flags, the counter and `sof_req_o` then show the new value in the following cycle. `irq_o` follows one edge later, and the combinational `wb_grant_o` and read data change as soon as their inputs change. The bench drives inputs on the falling edge and samples on the next falling edge for one-edge results. For `irq_o` it waits one more falling edge and checks that the interrupt is still low at the earlier one. Event masks, clear masks and enable masks are each swept over all 32 values.

// File: rtl/usbh_ist_pkg.sv
package usbh_ist_pkg;
  localparam int FLAG_N     = 5;
  localparam int BIT_OVR    = 0;
  localparam int BIT_WB     = 1;
  localparam int BIT_SOF    = 2;
  localparam int BIT_RESUME = 3;
  localparam int BIT_SYSERR = 4;
  localparam int MASTER_BIT = FLAG_N;
  localparam int ADDR_STATUS = 0;
  localparam int ADDR_ENABLE = 1;
  localparam int ADDR_OVRCNT = 2;
endpackage

// File: rtl/usbh_ist_flags.sv
module usbh_ist_flags #(
  parameter int N = 5
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flags_o
);
  logic [N-1:0] flag_q;

  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       flag_q[i] <= 1'b0;
      else if (set_i[i]) flag_q[i] <= 1'b1;  // set has priority
      else if (clr_i[i]) flag_q[i] <= 1'b0;
    end
  end

  assign flags_o = flag_q;

  p_set_wins_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i != '0) |=> ((flags_o & $past(set_i)) == $past(set_i)));

  p_w1c_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((clr_i & ~set_i) != '0) |=> ((flags_o & $past(clr_i & ~set_i)) == '0));

  p_no_spurious_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((flags_o & ~$past(flags_o) & ~$past(set_i)) == '0));
endmodule

// File: rtl/usbh_ist_ovr_cnt.sv
module usbh_ist_ovr_cnt #(
  parameter int CNT_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (inc_i) cnt_q <= cnt_q + 1'b1;  // wraps naturally
  end

  assign cnt_o = cnt_q;

  p_cnt_step_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inc_i |=> (cnt_o == CNT_W'($past(cnt_o) + 1'b1)));

  p_cnt_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !inc_i |=> $stable(cnt_o));
endmodule

// File: rtl/usbh_ist_irq.sv
module usbh_ist_irq #(
  parameter int N = 5
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] status_i,
  input  logic [N-1:0] en_i,
  input  logic         master_i,
  output logic         irq_o
);
  logic irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= master_i & (|(status_i & en_i));
  end

  assign irq_o = irq_q;

  p_irq_lat_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (irq_o == ($past(master_i) && ($past(status_i & en_i) != '0))));
endmodule

// File: rtl/usbh_int_status.sv
module usbh_int_status
  import usbh_ist_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sys_err_i,
  input  logic              resume_det_i,
  input  logic              sw_resume_i,
  input  logic              frame_start_i,
  input  logic              sched_ovr_i,
  input  logic              wb_done_i,
  input  logic              wb_req_i,
  output logic              wb_grant_o,
  output logic              sof_req_o,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              irq_o
);
  localparam int EN_W = FLAG_N + 1;

  logic [FLAG_N-1:0] set_vec, clr_vec, flags;
  logic [EN_W-1:0]   en_q;
  logic [CNT_W-1:0]  ovr_cnt;
  logic              sof_q;
  logic              sel_status, sel_enable, sel_ovrcnt;

  assign sel_status = (reg_addr_i == ADDR_W'(ADDR_STATUS));
  assign sel_enable = (reg_addr_i == ADDR_W'(ADDR_ENABLE));
  assign sel_ovrcnt = (reg_addr_i == ADDR_W'(ADDR_OVRCNT));

  always_comb begin
    set_vec             = '0;
    set_vec[BIT_SYSERR] = sys_err_i;
    set_vec[BIT_RESUME] = resume_det_i & ~sw_resume_i;  // own resume not reported
    set_vec[BIT_SOF]    = frame_start_i;
    set_vec[BIT_WB]     = wb_done_i;
    set_vec[BIT_OVR]    = sched_ovr_i;
  end

  assign clr_vec = (reg_we_i && sel_status) ? reg_wdata_i[FLAG_N-1:0] : '0;

  usbh_ist_flags #(.N(FLAG_N)) u_flags (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .set_i   (set_vec),
    .clr_i   (clr_vec),
    .flags_o (flags)
  );

  usbh_ist_ovr_cnt #(.CNT_W(CNT_W)) u_ovr_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .inc_i  (sched_ovr_i),
    .cnt_o  (ovr_cnt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     en_q <= '0;
    else if (reg_we_i && sel_enable) en_q <= reg_wdata_i[EN_W-1:0];
  end

  // token request aligned with the flag's first visible cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sof_q <= 1'b0;
    else         sof_q <= frame_start_i;
  end
  assign sof_req_o = sof_q;

  usbh_ist_irq #(.N(FLAG_N)) u_irq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .status_i (flags),
    .en_i     (en_q[FLAG_N-1:0]),
    .master_i (en_q[MASTER_BIT]),
    .irq_o    (irq_o)
  );

  // writeback interlock: a pending unread head blocks the next one
  assign wb_grant_o = wb_req_i & ~flags[BIT_WB];

  always_comb begin
    reg_rdata_o = '0;
    if (sel_status)      reg_rdata_o = DATA_W'(flags);
    else if (sel_enable) reg_rdata_o = DATA_W'(en_q);
    else if (sel_ovrcnt) reg_rdata_o = DATA_W'(ovr_cnt);
  end

  p_resume_mask_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sw_resume_i && !flags[BIT_RESUME]) |=> !flags[BIT_RESUME]);

  p_sof_sync_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_start_i |=> (sof_req_o && flags[BIT_SOF]));

  p_wb_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_done_i |=> !wb_grant_o);

  p_done_sets_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_done_i |=> flags[BIT_WB]);

  p_ovr_flag_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sched_ovr_i |=> flags[BIT_OVR]);
endmodule

// File: tb/usbh_int_status_bench.sv
module usbh_int_status_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        sys_err_i = 0, resume_det_i = 0, sw_resume_i = 0;
  logic        frame_start_i = 0, sched_ovr_i = 0, wb_done_i = 0, wb_req_i = 0;
  logic        wb_grant_o, sof_req_o, irq_o;
  logic        reg_we_i = 0;
  logic [3:0]  reg_addr_i = '0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;

  int checks = 0;
  int failures = 0;
  int exp_cnt = 0;
  logic [31:0] rv;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  usbh_int_status u_usbh_int_status (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk_i);
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    reg_addr_i = a;
    #1;
    d = reg_rdata_o;
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    reg_addr_i = a; reg_wdata_i = d; reg_we_i = 1;
    step();
    reg_we_i = 0; reg_wdata_i = '0;
  endtask

  // mask bits follow R11 positions
  task automatic drive_events(input logic [4:0] m);
    sys_err_i = m[4]; resume_det_i = m[3]; frame_start_i = m[2];
    wb_done_i = m[1]; sched_ovr_i = m[0];
    if (m[0]) exp_cnt = (exp_cnt + 1) % 4;
  endtask

  task automatic pulse(input logic [4:0] m);
    drive_events(m);
    step();
    drive_events(5'd0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    failures++;
    checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) step();
    rst_ni = 1'b1;
    step();
    // R1 reset state
    rd(0, rv); chk("R1 status", rv, 0);
    rd(1, rv); chk("R1 enable", rv, 0);
    rd(2, rv); chk("R1 count", rv, 0);
    chk("R1 irq", {31'd0, irq_o}, 0);
    chk("R1 sof", {31'd0, sof_req_o}, 0);

    // R11 / R5 / R7 / R10: event sweep
    for (int m = 0; m < 32; m++) begin
      pulse(5'(m));
      rd(0, rv); chk("R11 flag map", rv, 32'(m));
      rd(0, rv); chk("R10 read no side effect", rv, 32'(m));
      chk("R5 sof with flag", {31'd0, sof_req_o}, {31'd0, m[2]});
      wr(0, 32'h1F);
      chk("R5 sof one cycle", {31'd0, sof_req_o}, 0);
      rd(0, rv); chk("R2 clear all", rv, 0);
    end
    rd(2, rv); chk("R8 count after sweep", rv, 32'(exp_cnt));

    // R2 write-one-to-clear sweep
    for (int m = 0; m < 32; m++) begin
      pulse(5'h1F);
      wr(0, 32'(m));
      rd(0, rv); chk("R2 partial clear", rv, 32'(~m & 5'h1F));
      wr(0, 32'h1F);
    end
    pulse(5'h1F);
    wr(0, 32'hFFFF_FFE0);
    rd(0, rv); chk("R2 upper bits ignored", rv, 32'h1F);

    // R3 set wins over clear
    drive_events(5'h1F);
    wr(0, 32'h1F);
    drive_events(5'd0);
    rd(0, rv); chk("R3 set beats clear", rv, 32'h1F);
    wr(0, 32'h1F);

    // R4 resume masked by own resume
    sw_resume_i = 1;
    pulse(5'b01000);
    rd(0, rv); chk("R4 masked", rv, 0);
    sw_resume_i = 0;
    pulse(5'b01000);
    rd(0, rv); chk("R4 unmasked", rv, 32'h08);
    wr(0, 32'h1F);

    // R6 / R7 writeback interlock
    wb_req_i = 1;
    #1; chk("R6 grant when clear", {31'd0, wb_grant_o}, 1);
    pulse(5'b00010);
    rd(0, rv); chk("R7 done sets bit1", rv, 32'h02);
    chk("R6 grant blocked", {31'd0, wb_grant_o}, 0);
    repeat (4) step();
    chk("R6 still blocked", {31'd0, wb_grant_o}, 0);
    wr(0, 32'h01);
    chk("R6 clear other bit keeps block", {31'd0, wb_grant_o}, 0);
    wr(0, 32'h02);
    chk("R6 grant after clear", {31'd0, wb_grant_o}, 1);
    wb_req_i = 0;
    #1; chk("R6 no req no grant", {31'd0, wb_grant_o}, 0);

    // R8 counter wrap and write immunity
    for (int k = 0; k < 7; k++) begin
      pulse(5'b00001);
      rd(2, rv); chk("R8 count step", rv, 32'(exp_cnt));
    end
    wr(2, 32'hFFFF_FFFF);
    rd(2, rv); chk("R8 write ignored", rv, 32'(exp_cnt));
    wr(0, 32'h1F);

    // R9 enable sweep with all flags set
    pulse(5'h1F);
    for (int m = 0; m < 32; m++) begin
      wr(1, 32'h20 | 32'(m));
      step();
      chk("R9 enable mask", {31'd0, irq_o}, {31'd0, (m != 0)});
    end
    wr(1, 32'h1F);
    step();
    chk("R9 master off", {31'd0, irq_o}, 0);
    rd(1, rv); chk("R9 enable readback", rv, 32'h1F);
    wr(0, 32'h1F);
    wr(1, 32'h3F);
    step();
    chk("R9 idle", {31'd0, irq_o}, 0);
    pulse(5'b10000);
    chk("R9 not yet", {31'd0, irq_o}, 0);
    step();
    chk("R9 one cycle later", {31'd0, irq_o}, 1);
    wr(0, 32'h10);
    step();
    chk("R9 drops after clear", {31'd0, irq_o}, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule